// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block is the control state machine of one descriptor-driven DMA channel. It owns the channel's run state (idle, running or held), a sticky error flag, the enable and continue control bits, and the current source and destination descriptor pointers. A register front end delivers control writes as a single strobe that carries the enable, continue and continue-address values. The transfer engine reports each finished descriptor with its end command, its chaining type and the 64-bit link word stored behind it. The controller answers with descriptor fetch requests, done, pause and fetch-error pulses, and a two-bit status code.

There are three states. `ST_OFF` (code 0) is idle. `ST_RUN` (code 1) is running. `ST_PAU` (code 2) is held. A latched error makes the status read 3 whatever the internal state is. The transitions are as follows.
- **start** (OFF to RUN): a control write with enable 1.
- **fault** (RUN to OFF): a misaligned pointer at fetch time.
- **finish** (RUN to OFF): a completion with command 2, or any completion in register-pointer mode.
- **halt** (RUN to PAU): a completion with command 1.
- **chain** (RUN to RUN): any other completion, which advances the source pointer.
- **resume** (PAU to RUN): a control write with enable 1 and continue 1.
- **abandon** (PAU to OFF): a control write with enable 0 and continue 1.

Every pointer update and state change is registered, so it appears in the cycle after the event that caused it. At most one transition happens per cycle.

Top module: `dma_runctl`

## Requirements
- R1: After reset the status is 0, both pointers are 0, the enable and continue bits are 0, and no event or fetch pulse is high.
- R2: The status output is 0 for OFF, 1 for RUN and 2 for PAU, and it reads 3 whenever an error is latched.
- R3: A control write with enable 1 in OFF enters RUN in the next cycle and copies both start addresses into the pointers. One cycle later it pulses both the source fetch and the destination fetch.
- R4: In memory-pointer mode (`reg_mode`=0), a pointer due for fetch with any of its low four bits set produces the following in the next cycle: it latches the error, pulses the read-error event for that direction instead of the fetch, and enters OFF. In register-pointer mode no alignment check applies.
- R5: Every accepted completion pulses `done_evt` one cycle later. A completion with command 2, or any completion in register-pointer mode, also clears the enable bit and enters OFF.
- R6: A completion with command 1 in memory-pointer mode enters PAU, pulses `pause_evt` and leaves the source pointer unchanged.
- R7: A completion with command 0 or 3 in memory-pointer mode stays in RUN and advances the source pointer. One cycle later it pulses the source fetch alone.
- R8: The next descriptor pointer is the current pointer plus 16 for a linear descriptor (type 0), and the supplied link word for a linked descriptor (type 1).
- R9: A control write with enable 1 and continue 1 in PAU enters RUN and clears the continue bit. With continue-address 1, both pointers reload from the start addresses and both fetches follow. With continue-address 0, the source pointer advances past the halted descriptor (per R8) and only the source fetch follows.
- R10: A control write with enable 0 and continue 1 in PAU enters OFF. A control write in PAU with continue 0 leaves the state at PAU.
- R11: A completion is ignored, with no `done_evt` and no state or pointer change, unless the channel is in RUN with no fetch outstanding.
- R12: A control write with enable 1 in OFF clears a latched error, so the status leaves 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| en_in | input | 1 | Enable value written |
| cont_in | input | 1 | Continue value written |
| cont_addr_in | input | 1 | Continue-address select written (1 = reload from start) |
| reg_mode | input | 1 | 1 = descriptors held in registers, 0 = fetched from memory |
| src_start | input | AW | Source start address |
| dst_start | input | AW | Destination start address |
| desc_done | input | 1 | Descriptor completion from the transfer engine |
| desc_cmd | input | 2 | End command of the finished descriptor |
| desc_type | input | 1 | 0 = linear, 1 = linked |
| desc_link | input | AW | Link word stored after the finished descriptor |
| state_code | output | 2 | Status code |
| en_bit | output | 1 | Enable bit |
| cont_bit | output | 1 | Continue bit |
| src_ptr | output | AW | Current source descriptor pointer |
| dst_ptr | output | AW | Current destination descriptor pointer |
| src_fetch | output | 1 | Source descriptor fetch pulse |
| dst_fetch | output | 1 | Destination descriptor fetch pulse |
| done_evt | output | 1 | Descriptor done pulse |
| pause_evt | output | 1 | Channel held pulse |
| src_err_evt | output | 1 | Source descriptor read-error pulse |
| dst_err_evt | output | 1 | Destination descriptor read-error pulse |

## Verification
A wrong internal state shows on `state_code` at the next clock edge, because the status is decoded directly from the state register and the error flag. A wrong outstanding-fetch flag shows one cycle later, as a missing or extra fetch pulse. It can also show as a completion that was wrongly accepted or dropped, visible on `done_evt`. A wrong saved type or link of a halted descriptor stays hidden until the channel resumes with continue-address 0; the source pointer then shows it in the cycle after the resume.

// File: rtl/dmarc_pkg.sv
package dmarc_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_PAU = 2'd2
    } run_state_e;

    localparam logic [1:0] CMD_HALT   = 2'd1;
    localparam logic [1:0] CMD_STOP   = 2'd2;
    localparam logic [1:0] STATUS_ERR = 2'd3;
endpackage

// File: rtl/dmarc_ptr.sv
module dmarc_ptr #(
    parameter int AW         = 64,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          adv_type,
    input  logic [AW-1:0] adv_link,
    input  logic [AW-1:0] start,
    output logic [AW-1:0] ptr,
    output logic          misaligned
);
    localparam int AL = $clog2(DESC_BYTES);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= start;
        else if (adv)
            ptr_q <= adv_type ? adv_link : ptr_q + AW'(DESC_BYTES);
    end

    assign ptr        = ptr_q;
    assign misaligned = |ptr_q[AL-1:0];

    AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(start)); // R3
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !adv_type && !load) |=> ptr == $past(ptr) + AW'(DESC_BYTES)); // R8
endmodule

// File: rtl/dmarc_fsm.sv
module dmarc_fsm
    import dmarc_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          en_in,
    input  logic          cont_in,
    input  logic          cont_addr_in,
    input  logic          reg_mode,
    input  logic          desc_done,
    input  logic [1:0]    desc_cmd,
    input  logic          desc_type,
    input  logic [AW-1:0] desc_link,
    input  logic          src_mis,
    input  logic          dst_mis,
    output logic [1:0]    state_code,
    output logic          en_bit,
    output logic          cont_bit,
    output logic          load_start,
    output logic          src_adv,
    output logic          adv_type,
    output logic [AW-1:0] adv_link,
    output logic          src_fetch,
    output logic          dst_fetch,
    output logic          done_evt,
    output logic          pause_evt,
    output logic          src_err_evt,
    output logic          dst_err_evt
);
    run_state_e    state_q, state_d;
    logic          err_q, err_d, en_q, en_d, cont_q, cont_d;
    logic          pend_s_q, pend_s_d, pend_d_q, pend_d_d;
    logic          last_type_q, last_type_d;
    logic [AW-1:0] last_link_q, last_link_d;
    logic          sf_d, df_d, done_d, pause_d, serr_d, derr_d;
    logic          done_ok, fetch_go, src_bad, dst_bad;

    assign done_ok  = desc_done && state_q == ST_RUN && !pend_s_q && !pend_d_q;
    assign fetch_go = state_q == ST_RUN && (pend_s_q || pend_d_q);
    assign src_bad  = pend_s_q && src_mis && !reg_mode;
    assign dst_bad  = pend_d_q && dst_mis && !reg_mode;

    always_comb begin
        state_d     = state_q;
        err_d       = err_q;
        en_d        = en_q;
        cont_d      = cont_q;
        pend_s_d    = pend_s_q;
        pend_d_d    = pend_d_q;
        last_type_d = last_type_q;
        last_link_d = last_link_q;
        load_start  = 1'b0;
        src_adv     = 1'b0;
        adv_type    = desc_type;
        adv_link    = desc_link;
        sf_d = 1'b0; df_d = 1'b0; done_d = 1'b0;
        pause_d = 1'b0; serr_d = 1'b0; derr_d = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_wr) begin
                    en_d   = en_in;
                    cont_d = cont_in;
                    if (en_in) begin                      // start
                        err_d      = 1'b0;
                        load_start = 1'b1;
                        pend_s_d   = 1'b1;
                        pend_d_d   = 1'b1;
                        state_d    = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (ctrl_wr) begin
                    en_d   = en_in;
                    cont_d = cont_in;
                end
                if (fetch_go) begin
                    pend_s_d = 1'b0;
                    pend_d_d = 1'b0;
                    if (src_bad || dst_bad) begin         // fault
                        err_d   = 1'b1;
                        serr_d  = src_bad;
                        derr_d  = dst_bad;
                        state_d = ST_OFF;
                    end else begin
                        sf_d = pend_s_q;
                        df_d = pend_d_q;
                    end
                end else if (done_ok) begin
                    done_d      = 1'b1;
                    last_type_d = desc_type;
                    last_link_d = desc_link;
                    if (reg_mode || desc_cmd == CMD_STOP) begin   // finish
                        en_d    = 1'b0;
                        state_d = ST_OFF;
                    end else if (desc_cmd == CMD_HALT) begin      // halt
                        pause_d = 1'b1;
                        state_d = ST_PAU;
                    end else begin                                // chain
                        src_adv  = 1'b1;
                        pend_s_d = 1'b1;
                    end
                end
            end
            ST_PAU: begin
                if (ctrl_wr) begin
                    en_d   = en_in;
                    cont_d = cont_in;
                    if (cont_in && en_in) begin           // resume
                        err_d   = 1'b0;
                        cont_d  = 1'b0;
                        state_d = ST_RUN;
                        if (cont_addr_in) begin
                            load_start = 1'b1;
                            pend_s_d   = 1'b1;
                            pend_d_d   = 1'b1;
                        end else begin
                            src_adv  = 1'b1;
                            adv_type = last_type_q;
                            adv_link = last_link_q;
                            pend_s_d = 1'b1;
                        end
                    end else if (cont_in) begin           // abandon
                        state_d = ST_OFF;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_OFF;
            err_q       <= 1'b0;
            en_q        <= 1'b0;
            cont_q      <= 1'b0;
            pend_s_q    <= 1'b0;
            pend_d_q    <= 1'b0;
            last_type_q <= 1'b0;
            last_link_q <= '0;
        end else begin
            state_q     <= state_d;
            err_q       <= err_d;
            en_q        <= en_d;
            cont_q      <= cont_d;
            pend_s_q    <= pend_s_d;
            pend_d_q    <= pend_d_d;
            last_type_q <= last_type_d;
            last_link_q <= last_link_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_fetch <= 1'b0; dst_fetch <= 1'b0; done_evt <= 1'b0;
            pause_evt <= 1'b0; src_err_evt <= 1'b0; dst_err_evt <= 1'b0;
        end else begin
            src_fetch <= sf_d; dst_fetch <= df_d; done_evt <= done_d;
            pause_evt <= pause_d; src_err_evt <= serr_d; dst_err_evt <= derr_d;
        end
    end

    assign state_code = err_q ? STATUS_ERR : state_q;
    assign en_bit     = en_q;
    assign cont_bit   = cont_q;

    AST_ERR_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> state_q == ST_OFF); // R4
    AST_HALT_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !reg_mode && desc_cmd == CMD_HALT) |=> (state_code == 2'd2 && pause_evt)); // R6
    AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && (reg_mode || desc_cmd == CMD_STOP)) |=> (state_code == 2'd0 && !en_bit)); // R5
    AST_RESUME_CLEARS_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_PAU) |-> !cont_bit); // R9
    AST_FETCH_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (src_fetch || dst_fetch) |-> $past(state_q) == ST_RUN); // R3
endmodule

// File: rtl/dma_runctl.sv
module dma_runctl
    import dmarc_pkg::*;
#(
    parameter int AW         = 64,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          en_in,
    input  logic          cont_in,
    input  logic          cont_addr_in,
    input  logic          reg_mode,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic          desc_done,
    input  logic [1:0]    desc_cmd,
    input  logic          desc_type,
    input  logic [AW-1:0] desc_link,
    output logic [1:0]    state_code,
    output logic          en_bit,
    output logic          cont_bit,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic          src_fetch,
    output logic          dst_fetch,
    output logic          done_evt,
    output logic          pause_evt,
    output logic          src_err_evt,
    output logic          dst_err_evt
);
    localparam int NDIR = 2;
    localparam int AL   = $clog2(DESC_BYTES);

    logic          load_start, src_adv, adv_type;
    logic [AW-1:0] adv_link;
    logic [NDIR-1:0] adv_v, mis_v;
    logic [AW-1:0] start_v [NDIR];
    logic [AW-1:0] ptr_v   [NDIR];

    assign adv_v      = {1'b0, src_adv};
    assign start_v[0] = src_start;
    assign start_v[1] = dst_start;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        dmarc_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_start),
            .adv        (adv_v[g]),
            .adv_type   (adv_type),
            .adv_link   (adv_link),
            .start      (start_v[g]),
            .ptr        (ptr_v[g]),
            .misaligned (mis_v[g])
        );
    end

    assign src_ptr = ptr_v[0];
    assign dst_ptr = ptr_v[1];

    dmarc_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .en_in        (en_in),
        .cont_in      (cont_in),
        .cont_addr_in (cont_addr_in),
        .reg_mode     (reg_mode),
        .desc_done    (desc_done),
        .desc_cmd     (desc_cmd),
        .desc_type    (desc_type),
        .desc_link    (desc_link),
        .src_mis      (mis_v[0]),
        .dst_mis      (mis_v[1]),
        .state_code   (state_code),
        .en_bit       (en_bit),
        .cont_bit     (cont_bit),
        .load_start   (load_start),
        .src_adv      (src_adv),
        .adv_type     (adv_type),
        .adv_link     (adv_link),
        .src_fetch    (src_fetch),
        .dst_fetch    (dst_fetch),
        .done_evt     (done_evt),
        .pause_evt    (pause_evt),
        .src_err_evt  (src_err_evt),
        .dst_err_evt  (dst_err_evt)
    );

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_fetch && !reg_mode) |-> src_ptr[AL-1:0] == '0); // R4
endmodule

// File: tb/test_dma_runctl.sv
module test_dma_runctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 0, en_in = 0, cont_in = 0, cont_addr_in = 0, reg_mode = 0;
    logic [AW-1:0] src_start = '0, dst_start = '0, desc_link = '0;
    logic desc_done = 0, desc_type = 0;
    logic [1:0] desc_cmd = 0;
    logic [1:0] state_code;
    logic en_bit, cont_bit, src_fetch, dst_fetch, done_evt, pause_evt, src_err_evt, dst_err_evt;
    logic [AW-1:0] src_ptr, dst_ptr;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_runctl i_dma_runctl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .en_in(en_in), .cont_in(cont_in),
        .cont_addr_in(cont_addr_in), .reg_mode(reg_mode), .src_start(src_start),
        .dst_start(dst_start), .desc_done(desc_done), .desc_cmd(desc_cmd),
        .desc_type(desc_type), .desc_link(desc_link), .state_code(state_code),
        .en_bit(en_bit), .cont_bit(cont_bit), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .src_fetch(src_fetch), .dst_fetch(dst_fetch), .done_evt(done_evt),
        .pause_evt(pause_evt), .src_err_evt(src_err_evt), .dst_err_evt(dst_err_evt)
    );

    task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctrl(logic e, logic c, logic ca);
        ctrl_wr = 1; en_in = e; cont_in = c; cont_addr_in = ca;
        step();
        ctrl_wr = 0;
    endtask

    task automatic cmpl(logic [1:0] cmd, logic typ, logic [AW-1:0] lnk);
        desc_done = 1; desc_cmd = cmd; desc_type = typ; desc_link = lnk;
        step();
        desc_done = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [AW-1:0] s0, d0, lk, exp_s;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "status", state_code, 0);
        chk("R1", "src_ptr", src_ptr, 0);
        chk("R1", "dst_ptr", dst_ptr, 0);
        chk("R1", "en/cont", {en_bit, cont_bit}, 0);
        chk("R1", "pulses", {src_fetch, dst_fetch, done_evt, pause_evt, src_err_evt, dst_err_evt}, 0);

        // Sweep: mode x command x type
        for (int rm = 0; rm < 2; rm++) begin
            for (int cmd = 0; cmd < 4; cmd++) begin
                for (int ty = 0; ty < 2; ty++) begin
                    int idx = rm * 8 + cmd * 2 + ty;
                    reg_mode  = rm[0];
                    src_start = 64'h1000_0000_0000_0000 + AW'(idx * 256);
                    dst_start = 64'h0000_0000_0002_0000 + AW'(idx * 64);
                    lk        = 64'h0000_00AB_C000_0000 + AW'(idx * 32);
                    ctrl(1, 0, 0);
                    chk("R3", "status after start", state_code, 1);
                    chk("R3", "src_ptr load", src_ptr, src_start);
                    chk("R3", "dst_ptr load", dst_ptr, dst_start);
                    step();
                    chk("R3", "fetch pair", {src_fetch, dst_fetch}, 2'b11);
                    cmpl(cmd[1:0], ty[0], lk);
                    chk("R5", "done_evt", done_evt, 1);
                    if (rm == 1 || cmd == 2) begin
                        chk("R5", "finish status", state_code, 0);
                        chk("R5", "en cleared", en_bit, 0);
                    end else if (cmd == 1) begin
                        chk("R6", "halt status", state_code, 2);
                        chk("R6", "pause_evt", pause_evt, 1);
                        chk("R6", "src_ptr kept", src_ptr, src_start);
                        ctrl(0, 1, 0);
                        chk("R10", "abandon status", state_code, 0);
                    end else begin
                        exp_s = ty ? lk : src_start + 16;
                        chk("R7", "chain status", state_code, 1);
                        chk("R8", "next src_ptr", src_ptr, exp_s);
                        step();
                        chk("R7", "src-only fetch", {src_fetch, dst_fetch}, 2'b10);
                        cmpl(2, 0, 0);
                        chk("R5", "stop after chain", state_code, 0);
                    end
                end
            end
        end

        // Pause / resume paths
        reg_mode = 0;
        s0 = 64'h0000_0000_0000_4000; d0 = 64'h0000_0000_0000_8000;
        src_start = s0; dst_start = d0;
        ctrl(1, 0, 0); step();
        cmpl(1, 0, 0);
        chk("R6", "halt", state_code, 2);
        ctrl(1, 0, 0);
        chk("R10", "enable without continue stays held", state_code, 2);
        ctrl(0, 0, 0);
        chk("R10", "disable without continue stays held", state_code, 2);
        chk("R10", "en bit written 0", en_bit, 0);
        ctrl(1, 1, 0);
        chk("R9", "resume status", state_code, 1);
        chk("R9", "cont self-clear", cont_bit, 0);
        chk("R9", "advance linear", src_ptr, s0 + 16);
        step();
        chk("R9", "src-only fetch after advance", {src_fetch, dst_fetch}, 2'b10);
        lk = 64'h0000_0055_0000_1230;
        cmpl(1, 1, lk);
        chk("R6", "second halt", state_code, 2);
        ctrl(1, 1, 0);
        chk("R8", "advance linked on resume", src_ptr, lk);
        step();
        cmpl(1, 0, 0);
        src_start = 64'h0000_0000_0000_A000; dst_start = 64'h0000_0000_0000_B000;
        ctrl(1, 1, 1);
        chk("R9", "reload src", src_ptr, src_start);
        chk("R9", "reload dst", dst_ptr, dst_start);
        chk("R9", "cont cleared on reload", cont_bit, 0);
        step();
        chk("R9", "both fetch after reload", {src_fetch, dst_fetch}, 2'b11);
        cmpl(2, 0, 0);
        chk("R5", "stop", state_code, 0);

        // Completion ignored while a fetch is outstanding
        ctrl(1, 0, 0);
        desc_done = 1; desc_cmd = 2;
        step();
        desc_done = 0;
        chk("R11", "done ignored during fetch", done_evt, 0);
        chk("R11", "still running", state_code, 1);
        cmpl(2, 0, 0);
        chk("R11", "accepted after fetch", done_evt, 1);

        // Alignment errors
        src_start = 64'h0000_0000_0000_4008; dst_start = 64'h0000_0000_0000_8000;
        ctrl(1, 0, 0); step();
        chk("R4", "src err status", state_code, 3);
        chk("R4", "src err evt", {src_err_evt, dst_err_evt}, 2'b10);
        chk("R4", "no fetch on error", {src_fetch, dst_fetch}, 0);
        cmpl(0, 0, 0);
        chk("R11", "done ignored while off", done_evt, 0);
        chk("R2", "error status holds", state_code, 3);
        src_start = 64'h0000_0000_0000_4000; dst_start = 64'h0000_0000_0000_8004;
        ctrl(1, 0, 0);
        chk("R12", "error cleared by enable", state_code, 1);
        step();
        chk("R4", "dst err evt", {src_err_evt, dst_err_evt}, 2'b01);
        chk("R2", "dst err status", state_code, 3);
        reg_mode = 1;
        ctrl(1, 0, 0); step();
        chk("R4", "reg mode no alignment check", state_code, 1);
        chk("R4", "reg mode fetch", {src_fetch, dst_fetch}, 2'b11);
        cmpl(0, 0, 0);
        chk("R5", "reg mode finish", state_code, 0);

        summary();
    end
endmodule